// File: doc/BRIEF.md
# Boot-Overlay Bus Address Decoder

This block sits on the address side of a microprocessor bus with a 24-bit byte address and 16-bit data. For each bus cycle it decides which target answers: a 512 KiB RAM, a boot ROM, one of two 8-bit peripheral chips, a window of custom registers, or nothing (open bus). The selects are combinational from the address. A region table splits the address space into 64 slices of 256 KiB. The top six address bits pick a slice, and each slice carries a read permit and a write permit.

At reset a boot overlay places the ROM over the bottom 512 KiB, so the processor can fetch its reset vectors. Software then clears the overlay through an output bit of the first peripheral's parallel port, and RAM appears in that range from the next bus cycle on. The same port also carries an active-low indicator LED bit, which the block holds and presents as an active-high `led_on`.

The two peripherals share one address window but sit on opposite halves of the data bus. The decoder steers write bytes to them, gives each one a register number, and merges their read bytes into a 16-bit word. Unused lanes read as all ones.

Top module: `bootmap_decoder`

## Requirements
- R1: The region number is `bus_addr[23:18]` (64 regions of 256 KiB). Only regions 0, 1 and 63 have a read permit, and only regions 0 and 1 with the overlay off have a write permit. `mem_rd_en` is high only for a read of a readable region, and `mem_wr_en` only for a write to a writable one.
- R2: After reset, `overlay_on` is 1 and `led_on` is 0. With the overlay on, an access to 0x000000–0x07FFFF asserts `sel_rom` (read-only), and `mem_addr` equals `bus_addr[18:0]`.
- R3: With the overlay off, an access to 0x000000–0x07FFFF asserts `sel_ram` with read and write permit, and `mem_addr` equals `bus_addr[18:0]`.
- R4: An access to 0xFC0000–0xFFFFFF always asserts `sel_rom`, read-only, with `mem_addr` = {0, `bus_addr[17:0]`}.
- R5: A cycle with `ctl_port_we` high loads `overlay_on` from `ctl_port_bits[0]` and sets `led_on` to the inverse of `ctl_port_bits[1]`. The change is visible from the next clock cycle, and the access in the loading cycle still uses the old overlay.
- R6: An access to a region with no permits whose address satisfies `(bus_addr & 0xE00000) == 0xA00000` is a peripheral access. `per_reg` is `bus_addr[11:8]` for it and 0 otherwise.
- R7: In a peripheral access, `sel_per_a` is high when `bus_addr[12]` is 0 and `sel_per_b` is high when `bus_addr[13]` is 0. Both may be high together. `per_a_wdata` is `bus_wdata[7:0]` and `per_b_wdata` is `bus_wdata[15:8]`.
- R8: For a peripheral read, `io_rdata` starts from 0xFFFF. `per_a_rdata` replaces bits [7:0] when `sel_per_a` is high, and `per_b_rdata` replaces bits [15:8] when `sel_per_b` is high.
- R9: A no-permit, non-peripheral access with address 0xDFF000 to 0xDFF1BE inclusive asserts `sel_custom`. `reg_index` is `bus_addr[11:0] & 0xFFE` for it and 0 otherwise.
- R10: Any other no-permit access asserts `sel_open`, and `io_rdata` reads 0xFFFF.
- R11: With `bus_valid` low, no select and no memory enable is asserted, `mem_addr`, `per_reg` and `reg_index` are 0, and `io_rdata` is 0xFFFF.
- R12: A write to a ROM area still asserts `sel_rom` but keeps `mem_wr_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Address valid for this bus cycle |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 16 | Write data |
| ctl_port_we | input | 1 | First peripheral's port output update strobe |
| ctl_port_bits | input | 2 | Port bit 0 = overlay, bit 1 = LED (active low) |
| per_a_rdata | input | 8 | Read byte from peripheral A |
| per_b_rdata | input | 8 | Read byte from peripheral B |
| sel_ram | output | 1 | RAM selected |
| sel_rom | output | 1 | ROM selected |
| mem_rd_en | output | 1 | Permitted memory read |
| mem_wr_en | output | 1 | Permitted memory write |
| mem_addr | output | 19 | Byte offset inside the selected memory |
| sel_per_a | output | 1 | Peripheral A select (low lane) |
| sel_per_b | output | 1 | Peripheral B select (high lane) |
| per_reg | output | 4 | Peripheral register number |
| per_a_wdata | output | 8 | Write byte for peripheral A |
| per_b_wdata | output | 8 | Write byte for peripheral B |
| sel_custom | output | 1 | Custom register window selected |
| reg_index | output | 12 | Custom register offset, even-aligned |
| sel_open | output | 1 | Unmapped access |
| io_rdata | output | 16 | Read word for peripheral and open-bus cycles |
| overlay_on | output | 1 | Boot overlay state |
| led_on | output | 1 | Indicator LED, active high |

## Verification
The hardest case to reach is the bus cycle in which the port strobe and an access to the low range arrive together. That access must still see the old map, while the next cycle sees the new one. The bench drives both in one cycle and checks the low-range decode before and after the edge. It also sweeps every region with offsets placed on the lane-select bits and on the custom-window edges, once under each overlay state. It finishes with a second reset to confirm that the overlay returns after software has cleared it.

// File: rtl/bootmap_pkg.sv
`timescale 1ns/1ps
// Shared types for the boot-overlay address decoder.
// Assumes at most three kinds of memory target per region.
package bootmap_pkg;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RAM  = 2'd1,
        TGT_ROM  = 2'd2
    } target_e;

    typedef struct packed {
        target_e tgt;
        logic    rd_ok;
        logic    wr_ok;
    } region_t;

    localparam region_t REGION_EMPTY = '{tgt: TGT_NONE, rd_ok: 1'b0, wr_ok: 1'b0};
    localparam region_t REGION_RAM   = '{tgt: TGT_RAM,  rd_ok: 1'b1, wr_ok: 1'b1};
    localparam region_t REGION_ROM   = '{tgt: TGT_ROM,  rd_ok: 1'b1, wr_ok: 1'b0};

endpackage

// File: rtl/bootmap_region_table.sv
`timescale 1ns/1ps
// Region table: one entry per address slice, giving target and permits.
// Assumes the overlay slices are the lowest ones and the fixed ROM slices
// are the highest ones; every other slice has no permits.
module bootmap_region_table
    import bootmap_pkg::*;
#(
    parameter int NREG        = 64,
    parameter int OVL_REGIONS = 2,
    parameter int ROM_FIRST   = 63,
    parameter int IDX_W       = $clog2(NREG)
) (
    input  logic             overlay,
    input  logic [IDX_W-1:0] idx,
    output region_t          entry
);

    region_t map [NREG];

    // Build each slice's entry; the overlay slices follow the overlay flag.
    for (genvar g = 0; g < NREG; g++) begin : g_region
        if (g < OVL_REGIONS) begin : g_ovl
            assign map[g] = overlay ? REGION_ROM : REGION_RAM;
        end else if (g >= ROM_FIRST) begin : g_rom
            assign map[g] = REGION_ROM;
        end else begin : g_empty
            assign map[g] = REGION_EMPTY;
        end
    end

    // Look up the slice addressed by the current cycle.
    assign entry = map[idx];

endmodule

// File: rtl/bootmap_overlay_reg.sv
`timescale 1ns/1ps
// Holds the boot overlay flag and the LED bit from the peripheral port.
// Assumes the port strobe is a single-cycle pulse; reset restores the overlay.
module bootmap_overlay_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       port_we,
    input  logic [1:0] port_bits,
    output logic       overlay_q,
    output logic       led_on
);

    logic led_n_q;

    // Capture overlay and LED bits on each port update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overlay_q <= 1'b1;
            led_n_q   <= 1'b1;
        end else if (port_we) begin
            overlay_q <= port_bits[0];
            led_n_q   <= port_bits[1];
        end
    end

    assign led_on = ~led_n_q;

    // R5: the overlay follows the port bit one cycle after the strobe.
    p_overlay_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        port_we |=> (overlay_q == $past(port_bits[0])) && (led_on == !$past(port_bits[1])));

    // R2: leaving reset, the overlay is on and the LED is dark.
    p_reset_state_r2: assert property (@(posedge clk)
        $rose(rst_n) |-> (overlay_q && !led_on));

endmodule

// File: rtl/bootmap_mem_steer.sv
`timescale 1ns/1ps
// Turns a region entry into RAM/ROM selects, permitted enables and an offset.
// Assumes the fixed high ROM span is no wider than the overlay span.
module bootmap_mem_steer
    import bootmap_pkg::*;
#(
    parameter int MEM_AW       = 19,
    parameter int HI_SPAN_BITS = 18
) (
    input  logic              valid,
    input  logic              rd,
    input  region_t           entry,
    input  logic              is_high,
    input  logic [MEM_AW-1:0] addr_lo,
    output logic              sel_ram,
    output logic              sel_rom,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [MEM_AW-1:0] mem_addr
);

    // Target selects and permission-gated enables.
    always_comb begin
        sel_ram   = valid && (entry.tgt == TGT_RAM);
        sel_rom   = valid && (entry.tgt == TGT_ROM);
        mem_rd_en = valid && rd && entry.rd_ok;
        mem_wr_en = valid && !rd && entry.wr_ok;
    end

    // Offset inside the selected memory; the high ROM span is rebased to zero.
    always_comb begin
        if (!(sel_ram || sel_rom)) begin
            mem_addr = '0;
        end else if (is_high) begin
            mem_addr = {{(MEM_AW-HI_SPAN_BITS){1'b0}}, addr_lo[HI_SPAN_BITS-1:0]};
        end else begin
            mem_addr = addr_lo;
        end
    end

endmodule

// File: rtl/bootmap_io_decode.sv
`timescale 1ns/1ps
// Decodes the no-permit slices into peripheral, custom window and open bus,
// and forms the merged read word. Assumes a two-lane data bus.
module bootmap_io_decode #(
    parameter int                ADDR_W       = 24,
    parameter int                DATA_W       = 16,
    parameter int                IDX_W        = 12,
    parameter int                PREG_W       = 4,
    parameter int                PREG_LSB     = 8,
    parameter int                SEL_A_BIT    = 12,
    parameter int                SEL_B_BIT    = 13,
    parameter logic [ADDR_W-1:0] PERIPH_MASK  = 24'hE0_0000,
    parameter logic [ADDR_W-1:0] PERIPH_MATCH = 24'hA0_0000,
    parameter logic [ADDR_W-1:0] CUSTOM_LO    = 24'hDF_F000,
    parameter logic [ADDR_W-1:0] CUSTOM_HI    = 24'hDF_F1BE,
    parameter logic [IDX_W-1:0]  IDX_MASK     = 12'hFFE,
    parameter int                LANE_W       = DATA_W / 2
) (
    input  logic              valid,
    input  logic              rd,
    input  logic              no_map,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] per_a_rdata,
    input  logic [LANE_W-1:0] per_b_rdata,
    output logic              sel_per_a,
    output logic              sel_per_b,
    output logic [PREG_W-1:0] per_reg,
    output logic              sel_custom,
    output logic [IDX_W-1:0]  reg_index,
    output logic              sel_open,
    output logic [DATA_W-1:0] io_rdata
);

    logic periph_hit;
    logic custom_hit;

    // Classify the no-permit access in priority order.
    always_comb begin
        periph_hit = valid && no_map && ((addr & PERIPH_MASK) == PERIPH_MATCH);
        custom_hit = valid && no_map && !periph_hit &&
                     (addr >= CUSTOM_LO) && (addr <= CUSTOM_HI);
        sel_open   = valid && no_map && !periph_hit && !custom_hit;
        sel_custom = custom_hit;
    end

    // Active-low chip-select bits pick the peripherals on their lanes.
    always_comb begin
        sel_per_a = periph_hit && !addr[SEL_A_BIT];
        sel_per_b = periph_hit && !addr[SEL_B_BIT];
        per_reg   = periph_hit ? addr[PREG_LSB +: PREG_W] : '0;
        reg_index = custom_hit ? (addr[IDX_W-1:0] & IDX_MASK) : '0;
    end

    // Merge read bytes over an all-ones word; unselected lanes float high.
    always_comb begin
        io_rdata = '1;
        if (rd && sel_per_a) io_rdata[LANE_W-1:0]      = per_a_rdata;
        if (rd && sel_per_b) io_rdata[DATA_W-1:LANE_W] = per_b_rdata;
    end

endmodule

// File: rtl/bootmap_decoder.sv
`timescale 1ns/1ps
// Top of the boot-overlay bus address decoder. Selects are combinational
// from the address; only the overlay and LED bits are state.
// Assumes one bus cycle per clock and a synchronous active-low reset.
module bootmap_decoder
    import bootmap_pkg::*;
#(
    parameter int  ADDR_W       = 24,
    parameter int  DATA_W       = 16,
    parameter int  REGION_BITS  = 6,
    parameter int  OVL_REGIONS  = 2,
    parameter int  ROM_FIRST    = 63,
    parameter int  IDX_W        = 12,
    parameter int  PREG_W       = 4,
    localparam int NREG         = 1 << REGION_BITS,
    localparam int REGION_SHIFT = ADDR_W - REGION_BITS,
    localparam int MEM_AW       = REGION_SHIFT + $clog2(OVL_REGIONS),
    localparam int HI_SPAN_BITS = REGION_SHIFT + $clog2(NREG - ROM_FIRST),
    localparam int LANE_W       = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              ctl_port_we,
    input  logic [1:0]        ctl_port_bits,
    input  logic [LANE_W-1:0] per_a_rdata,
    input  logic [LANE_W-1:0] per_b_rdata,
    output logic              sel_ram,
    output logic              sel_rom,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              sel_per_a,
    output logic              sel_per_b,
    output logic [PREG_W-1:0] per_reg,
    output logic [LANE_W-1:0] per_a_wdata,
    output logic [LANE_W-1:0] per_b_wdata,
    output logic              sel_custom,
    output logic [IDX_W-1:0]  reg_index,
    output logic              sel_open,
    output logic [DATA_W-1:0] io_rdata,
    output logic              overlay_on,
    output logic              led_on
);

    logic [REGION_BITS-1:0] region_idx;
    region_t                entry;
    logic                   is_high;
    logic                   no_map;

    // Region number and derived flags for this cycle.
    always_comb begin
        region_idx = bus_addr[ADDR_W-1 -: REGION_BITS];
        is_high    = int'(region_idx) >= ROM_FIRST;
        no_map     = (entry.tgt == TGT_NONE);
    end

    bootmap_overlay_reg u_overlay (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_we   (ctl_port_we),
        .port_bits (ctl_port_bits),
        .overlay_q (overlay_on),
        .led_on    (led_on)
    );

    bootmap_region_table #(
        .NREG        (NREG),
        .OVL_REGIONS (OVL_REGIONS),
        .ROM_FIRST   (ROM_FIRST),
        .IDX_W       (REGION_BITS)
    ) u_table (
        .overlay (overlay_on),
        .idx     (region_idx),
        .entry   (entry)
    );

    bootmap_mem_steer #(
        .MEM_AW       (MEM_AW),
        .HI_SPAN_BITS (HI_SPAN_BITS)
    ) u_mem (
        .valid     (bus_valid),
        .rd        (bus_rd),
        .entry     (entry),
        .is_high   (is_high),
        .addr_lo   (bus_addr[MEM_AW-1:0]),
        .sel_ram   (sel_ram),
        .sel_rom   (sel_rom),
        .mem_rd_en (mem_rd_en),
        .mem_wr_en (mem_wr_en),
        .mem_addr  (mem_addr)
    );

    bootmap_io_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .PREG_W (PREG_W)
    ) u_io (
        .valid       (bus_valid),
        .rd          (bus_rd),
        .no_map      (no_map),
        .addr        (bus_addr),
        .per_a_rdata (per_a_rdata),
        .per_b_rdata (per_b_rdata),
        .sel_per_a   (sel_per_a),
        .sel_per_b   (sel_per_b),
        .per_reg     (per_reg),
        .sel_custom  (sel_custom),
        .reg_index   (reg_index),
        .sel_open    (sel_open),
        .io_rdata    (io_rdata)
    );

    // Byte-lane steering of write data to the two peripherals.
    assign per_a_wdata = bus_wdata[LANE_W-1:0];
    assign per_b_wdata = bus_wdata[DATA_W-1:LANE_W];

    // R1: at most one target class answers a cycle.
    p_one_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_ram, sel_rom, sel_custom, sel_open, (sel_per_a | sel_per_b)}));

    // R11: an idle bus selects nothing.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> !(sel_ram | sel_rom | sel_per_a | sel_per_b | sel_custom |
                         sel_open | mem_rd_en | mem_wr_en));

    // R4: the top slice is always read-only ROM.
    p_rom_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (&bus_addr[ADDR_W-1 -: REGION_BITS])) |-> (sel_rom && !mem_wr_en));

    // R2/R3: the low range follows the registered overlay flag.
    p_low_follows_overlay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (bus_addr[ADDR_W-1:MEM_AW] == '0)) |->
            (overlay_on ? (sel_rom && !mem_wr_en) : sel_ram));

    // R7: each peripheral select agrees with its active-low address bit.
    p_lane_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_per_a |-> !bus_addr[12]) and (sel_per_b |-> !bus_addr[13]));

    // R10: open bus reads all ones.
    p_open_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sel_open |-> (io_rdata == '1));

    // R12: ROM is never written.
    p_rom_no_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rom |-> !mem_wr_en);

endmodule

// File: tb/bootmap_decoder_tb_top.sv
`timescale 1ns/1ps
module bootmap_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_rd = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        ctl_port_we = 1'b0;
    logic [1:0]  ctl_port_bits = 2'b00;
    logic [7:0]  per_a_rdata = '0;
    logic [7:0]  per_b_rdata = '0;

    logic        sel_ram, sel_rom, mem_rd_en, mem_wr_en;
    logic [18:0] mem_addr;
    logic        sel_per_a, sel_per_b;
    logic [3:0]  per_reg;
    logic [7:0]  per_a_wdata, per_b_wdata;
    logic        sel_custom;
    logic [11:0] reg_index;
    logic        sel_open;
    logic [15:0] io_rdata;
    logic        overlay_on, led_on;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bootmap_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ctl_port_we(ctl_port_we),
        .ctl_port_bits(ctl_port_bits), .per_a_rdata(per_a_rdata),
        .per_b_rdata(per_b_rdata), .sel_ram(sel_ram), .sel_rom(sel_rom),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .sel_per_a(sel_per_a), .sel_per_b(sel_per_b), .per_reg(per_reg),
        .per_a_wdata(per_a_wdata), .per_b_wdata(per_b_wdata),
        .sel_custom(sel_custom), .reg_index(reg_index), .sel_open(sel_open),
        .io_rdata(io_rdata), .overlay_on(overlay_on), .led_on(led_on)
    );

    logic [74:0] act_vec;
    assign act_vec = {sel_ram, sel_rom, mem_rd_en, mem_wr_en, mem_addr,
                      sel_per_a, sel_per_b, per_reg, per_a_wdata, per_b_wdata,
                      sel_custom, reg_index, sel_open, io_rdata};

    // Expected outputs from the requirements.
    function automatic logic [74:0] expect_out(logic [23:0] a, logic rd, logic ovl,
                                               logic [15:0] wd, logic [7:0] ra, logic [7:0] rb);
        logic sr = 0, so = 0, re, we, pa = 0, pb = 0, sc = 0, sop = 0;
        logic [18:0] ma = '0;
        logic [3:0]  pr = '0;
        logic [11:0] ri = '0;
        logic [15:0] io = 16'hFFFF;
        int region = int'(a[23:18]);
        if (region < 2) begin
            if (ovl) so = 1; else sr = 1;
            ma = a[18:0];
        end else if (region == 63) begin
            so = 1;
            ma = {1'b0, a[17:0]};
        end else if (a[23:21] == 3'b101) begin
            pa = !a[12];
            pb = !a[13];
            pr = a[11:8];
            if (rd && pa) io[7:0]  = ra;
            if (rd && pb) io[15:8] = rb;
        end else if (a >= 24'hDFF000 && a <= 24'hDFF1BE) begin
            sc = 1;
            ri = a[11:0] & 12'hFFE;
        end else begin
            sop = 1;
        end
        re = rd & (sr | so);
        we = !rd & sr;
        return {sr, so, re, we, ma, pa, pb, pr, wd[7:0], wd[15:8], sc, ri, sop, io};
    endfunction

    function automatic string tag_for(logic [23:0] a, logic rd, logic ovl);
        int region = int'(a[23:18]);
        if (region < 2)                               return ovl ? "R2" : "R3";
        if (region == 63)                             return rd ? "R4" : "R12";
        if (a[23:21] == 3'b101)                       return rd ? "R6/R8" : "R6/R7";
        if (a >= 24'hDFF000 && a <= 24'hDFF1BE)       return "R9";
        return "R10";
    endfunction

    function automatic logic [17:0] offs(int k);
        case (k)
            0: return 18'h00000;
            1: return 18'h01001;
            2: return 18'h02000;
            3: return 18'h03000;
            4: return 18'h00F3F;
            5: return 18'h3EFFE;
            6: return 18'h3F000;
            7: return 18'h3F1BE;
            8: return 18'h3F1BF;
            default: return 18'h3FFFF;
        endcase
    endfunction

    task automatic check(string tag, logic [74:0] act, logic [74:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual %h expected %h", tag, bus_addr, act, exp);
        end
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // R1 sweep: every region, edge offsets, both directions.
    task automatic sweep(logic ovl);
        for (int r = 0; r < 64; r++) begin
            for (int k = 0; k < 10; k++) begin
                for (int d = 0; d < 2; d++) begin
                    logic [23:0] a = {r[5:0], offs(k)};
                    bus_valid   = 1'b1;
                    bus_rd      = d[0];
                    bus_addr    = a;
                    bus_wdata   = a[15:0] ^ 16'h9C35;
                    per_a_rdata = 8'hA5 ^ r[7:0];
                    per_b_rdata = 8'h3C ^ k[7:0];
                    #2;
                    check({"R1/", tag_for(a, d[0], ovl)}, act_vec,
                          expect_out(a, d[0], ovl, bus_wdata, per_a_rdata, per_b_rdata));
                    step();
                end
            end
        end
        bus_valid = 1'b0;
    endtask

    task automatic idle_probe(logic [23:0] a);
        bus_valid = 1'b0;
        bus_rd    = 1'b1;
        bus_addr  = a;
        bus_wdata = 16'h1234;
        #2;
        check("R11", act_vec, {4'b0, 19'b0, 2'b0, 4'b0, 8'h34, 8'h12, 1'b0, 12'b0, 1'b0, 16'hFFFF});
        step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #2;
        check_bit("R2 overlay after reset", overlay_on, 1'b1);
        check_bit("R2 led after reset", led_on, 1'b0);
        step();

        sweep(1'b1);

        idle_probe(24'h000000);
        idle_probe(24'hBFE001);
        idle_probe(24'hDFF000);
        idle_probe(24'h123456);

        // R5: strobe and low-range read in the same cycle.
        ctl_port_we   = 1'b1;
        ctl_port_bits = 2'b00;
        bus_valid     = 1'b1;
        bus_rd        = 1'b1;
        bus_addr      = 24'h000100;
        #2;
        check_bit("R5 old map same cycle", sel_rom, 1'b1);
        check_bit("R5 no ram same cycle", sel_ram, 1'b0);
        step();
        ctl_port_we = 1'b0;
        #2;
        check_bit("R5 ram next cycle", sel_ram, 1'b1);
        check_bit("R5 overlay cleared", overlay_on, 1'b0);
        check_bit("R5 led lit", led_on, 1'b1);
        step();

        sweep(1'b0);

        // R5: set overlay again with LED dark, then clear.
        ctl_port_we   = 1'b1;
        ctl_port_bits = 2'b11;
        step();
        ctl_port_we = 1'b0;
        #2;
        check_bit("R5 overlay set", overlay_on, 1'b1);
        check_bit("R5 led dark", led_on, 1'b0);
        step();
        ctl_port_we   = 1'b1;
        ctl_port_bits = 2'b10;
        step();
        ctl_port_we = 1'b0;
        #2;
        check_bit("R5 overlay clear led dark", overlay_on, 1'b0);
        check_bit("R5 led stays dark", led_on, 1'b0);
        step();

        // R2: a second reset restores the overlay.
        rst_n = 1'b0;
        step();
        step();
        rst_n     = 1'b1;
        bus_valid = 1'b1;
        bus_rd    = 1'b0;
        bus_addr  = 24'h07FFFE;
        #2;
        check_bit("R2 overlay after second reset", overlay_on, 1'b1);
        check_bit("R2 low range is rom", sel_rom, 1'b1);
        check_bit("R12 rom write blocked", mem_wr_en, 1'b0);
        step();
        bus_valid = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule